// File: doc/BRIEF.md
# Dual-Mode Timer with Watchdog

This block is a timer peripheral built around two 32-bit counters, a low half and a high half, each with its own period register. A mode field splits the pair in one of three ways. It can run them chained as a single 64-bit timer. It can run them as two independent 32-bit timers. Or it can run them as a watchdog, which counts continuously and must be serviced before it reaches its period. In the first two modes each half has its own enable. Each half can also choose between the internal divided tick and an edge on its own external input pin.

Software reaches the block through a simple register slave. Writes are single-cycle strobes and reads are combinational. A period match produces a one-cycle event pulse, and a selected half's event is also routed to the timer output pin. Once the watchdog is armed it locks the configuration until reset. It drives a timeout output that stays high once raised.

Top module: `tmr_dual_wd`

## Requirements
- R1: After reset both counters read zero, all outputs are low, the mode field reads 0 (chained) and the control register reads zero.
- R2: Register offsets are: 0x04 clock-speed (reads the divide ratio, 6), 0x10 counter low, 0x14 counter high, 0x18 period low, 0x1C period high, 0x20 control, 0x24 mode, 0x28 watchdog control. Every other offset reads zero, and writes to it change nothing.
- R3: In chained mode (mode field 0), each enabled tick of the low half increments the low counter. The high counter increments when the low counter wraps from all ones. A tick taken while both halves equal their periods clears both halves and pulses evt_lo for one cycle.
- R4: In dual mode (mode field 1), each half counts its own ticks and compares against its own period. A tick taken at its period clears that half and pulses that half's event output (evt_lo or evt_hi), so a period P gives one event every P+1 ticks.
- R5: Control bit 1 (low) and bit 3 (high) select the external input of that half. ext_in0 feeds the low half and ext_in1 feeds the high half. Each rising edge of the input, after a two-flop synchronizer, advances the counter once, and tick_en is then ignored by that half.
- R6: tmr_out carries evt_hi when control bit 4 is set and evt_lo when it is clear.
- R7: In watchdog mode the count runs on tick_en regardless of the enables. A write of 0xA5C6 and then, as the next watchdog-control write, 0xDA7E (key in bits 15:0 at 0x28) clears both counters. Any other order leaves the count running.
- R8: Writing a mode field with bit 1 set enters watchdog mode (mode reads 2). After that, writes to the mode, counter and period registers are ignored until reset.
- R9: In watchdog mode, a tick taken with both halves at their periods raises wd_expire. wd_expire then stays high until reset. Watchdog-control bit 0 reads watchdog active, bit 1 reads key armed, and bit 2 reads expired.
- R10: A counter write loads the written value and overrides a tick in the same cycle, and no event pulse is produced for that cycle.
- R11: Control bit 0 enables the low half and bit 2 enables the high half. A disabled half holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Internal divided count tick, one core cycle wide |
| ext_in0 | input | 1 | External count input for the low half |
| ext_in1 | input | 1 | External count input for the high half |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| tmr_out | output | 1 | Selected half's event pulse |
| evt_lo | output | 1 | Low half / 64-bit event pulse |
| evt_hi | output | 1 | High half event pulse |
| wd_expire | output | 1 | Watchdog timeout, held until reset |

## Verification
The assertions assume that tick_en is a single-cycle strobe synchronous to clk. They also assume that register writes are one-cycle pulses with a stable address and data, and that external inputs may change at any time only because they pass through the synchronizer. The bench drives every input on the falling edge. It holds each external level for several cycles so every edge survives synchronization, and it sets periods before arming the watchdog so that the lock never hides stimulus that a check depends on. Random periods and enables are kept small so that the expected counts and event totals come from a modulo rule.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [7:0] OFF_CLKSPD = 8'h04;
  localparam logic [7:0] OFF_CNTLO  = 8'h10;
  localparam logic [7:0] OFF_CNTHI  = 8'h14;
  localparam logic [7:0] OFF_PRDLO  = 8'h18;
  localparam logic [7:0] OFF_PRDHI  = 8'h1C;
  localparam logic [7:0] OFF_CTRL   = 8'h20;
  localparam logic [7:0] OFF_MODE   = 8'h24;
  localparam logic [7:0] OFF_WDCTL  = 8'h28;

  localparam logic [15:0] WD_KEY_FIRST  = 16'hA5C6;
  localparam logic [15:0] WD_KEY_SECOND = 16'hDA7E;

  typedef enum logic [1:0] {
    MODE_CHAIN = 2'b00,
    MODE_DUAL  = 2'b01,
    MODE_WDOG  = 2'b10
  } mode_e;

  typedef struct packed {
    logic out_hi;
    logic hi_ext;
    logic hi_en;
    logic lo_ext;
    logic lo_en;
  } ctrl_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

  // R5
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8,
  parameter int CLK_DIV = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  cnt_lo,
  input  logic [CNT_W-1:0]  cnt_hi,
  input  logic              expired,
  output logic [CNT_W-1:0]  prd_lo,
  output logic [CNT_W-1:0]  prd_hi,
  output ctrl_t             ctrl,
  output mode_e             mode,
  output logic              ld_lo,
  output logic              ld_hi,
  output logic              svc,
  output logic              wd_active
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic [CNT_W-1:0] prd_lo_q, prd_lo_d, prd_hi_q, prd_hi_d;
  ctrl_t            ctrl_q, ctrl_d;
  mode_e            mode_q, mode_d;
  logic             armed_q, armed_d;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  logic wr_prdlo, wr_prdhi, wr_ctrl, wr_mode, wr_wd;

  always_comb begin
    wr_prdlo  = bus_wr && hit(bus_addr, OFF_PRDLO);
    wr_prdhi  = bus_wr && hit(bus_addr, OFF_PRDHI);
    wr_ctrl   = bus_wr && hit(bus_addr, OFF_CTRL);
    wr_mode   = bus_wr && hit(bus_addr, OFF_MODE);
    wr_wd     = bus_wr && hit(bus_addr, OFF_WDCTL);
    wd_active = (mode_q == MODE_WDOG);

    prd_lo_d = prd_lo_q;
    prd_hi_d = prd_hi_q;
    ctrl_d   = ctrl_q;
    mode_d   = mode_q;
    armed_d  = armed_q;
    svc      = 1'b0;

    if (wr_prdlo && !wd_active) prd_lo_d = bus_wdata;
    if (wr_prdhi && !wd_active) prd_hi_d = bus_wdata;
    if (wr_ctrl) ctrl_d = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    if (wr_mode && !wd_active) begin
      if (bus_wdata[1])      mode_d = MODE_WDOG;
      else if (bus_wdata[0]) mode_d = MODE_DUAL;
      else                   mode_d = MODE_CHAIN;
    end
    if (wr_wd && wd_active) begin
      armed_d = (bus_wdata[15:0] == WD_KEY_FIRST);
      svc     = armed_q && (bus_wdata[15:0] == WD_KEY_SECOND);
    end

    ld_lo = bus_wr && hit(bus_addr, OFF_CNTLO) && !wd_active;
    ld_hi = bus_wr && hit(bus_addr, OFF_CNTHI) && !wd_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_lo_q <= '0;
      prd_hi_q <= '0;
      ctrl_q   <= '0;
      mode_q   <= MODE_CHAIN;
      armed_q  <= 1'b0;
    end else begin
      prd_lo_q <= prd_lo_d;
      prd_hi_q <= prd_hi_d;
      ctrl_q   <= ctrl_d;
      mode_q   <= mode_d;
      armed_q  <= armed_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, OFF_CLKSPD))     bus_rdata = CNT_W'(CLK_DIV);
    else if (hit(bus_addr, OFF_CNTLO)) bus_rdata = cnt_lo;
    else if (hit(bus_addr, OFF_CNTHI)) bus_rdata = cnt_hi;
    else if (hit(bus_addr, OFF_PRDLO)) bus_rdata = prd_lo_q;
    else if (hit(bus_addr, OFF_PRDHI)) bus_rdata = prd_hi_q;
    else if (hit(bus_addr, OFF_CTRL))  bus_rdata = CNT_W'(ctrl_q);
    else if (hit(bus_addr, OFF_MODE))  bus_rdata = CNT_W'(mode_q);
    else if (hit(bus_addr, OFF_WDCTL)) bus_rdata = CNT_W'({expired, armed_q, wd_active});
  end

  assign prd_lo = prd_lo_q;
  assign prd_hi = prd_hi_q;
  assign ctrl   = ctrl_q;
  assign mode   = mode_q;

  // R8
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_active |=> wd_active);

  // R8
  prd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_active |=> $stable(prd_lo_q) && $stable(prd_hi_q));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            mode,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] prd_lo,
  input  logic [CNT_W-1:0] prd_hi,
  input  logic             tick_en,
  input  logic [1:0]       ext_rise,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             svc,
  output logic [CNT_W-1:0] cnt_lo,
  output logic [CNT_W-1:0] cnt_hi,
  output logic             evt_lo,
  output logic             evt_hi,
  output logic             wd_expire
);
  logic [CNT_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic             elo_q, elo_d, ehi_q, ehi_d, exp_q, exp_d;
  logic             tk_lo, tk_hi, adv64, match64, lo_wrap;

  always_comb begin
    tk_lo   = ctrl.lo_ext ? ext_rise[0] : tick_en;
    tk_hi   = ctrl.hi_ext ? ext_rise[1] : tick_en;
    match64 = (lo_q == prd_lo) && (hi_q == prd_hi);
    lo_wrap = &lo_q;
    adv64   = (mode == MODE_WDOG) ? tick_en : (ctrl.lo_en && tk_lo);

    lo_d  = lo_q;
    hi_d  = hi_q;
    elo_d = 1'b0;
    ehi_d = 1'b0;
    exp_d = exp_q;

    if (mode == MODE_DUAL) begin
      if (ctrl.lo_en && tk_lo) begin
        if (lo_q == prd_lo) begin
          lo_d  = '0;
          elo_d = 1'b1;
        end else begin
          lo_d = lo_q + 1'b1;
        end
      end
      if (ctrl.hi_en && tk_hi) begin
        if (hi_q == prd_hi) begin
          hi_d  = '0;
          ehi_d = 1'b1;
        end else begin
          hi_d = hi_q + 1'b1;
        end
      end
    end else if (adv64) begin
      if (match64) begin
        lo_d = '0;
        hi_d = '0;
        if (mode == MODE_WDOG) exp_d = 1'b1;
        else                   elo_d = 1'b1;
      end else begin
        lo_d = lo_q + 1'b1;
        if (lo_wrap) hi_d = hi_q + 1'b1;
      end
    end

    if (svc) begin
      lo_d = '0;
      hi_d = '0;
    end
    if (ld_lo) begin
      lo_d  = ld_val;
      elo_d = 1'b0;
    end
    if (ld_hi) begin
      hi_d  = ld_val;
      ehi_d = 1'b0;
      if (mode != MODE_DUAL) elo_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      elo_q <= 1'b0;
      ehi_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      elo_q <= elo_d;
      ehi_q <= ehi_d;
      exp_q <= exp_d;
    end
  end

  assign cnt_lo    = lo_q;
  assign cnt_hi    = hi_q;
  assign evt_lo    = elo_q;
  assign evt_hi    = ehi_q;
  assign wd_expire = exp_q;

  // R4
  lo_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lo |-> cnt_lo == '0);

  // R4
  hi_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hi |-> cnt_hi == '0);

  // R9
  expire_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(wd_expire));

  // R9
  expire_in_wd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_expire) |-> mode == MODE_WDOG);

  // R7
  service_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> cnt_lo == '0 && cnt_hi == '0);

  // R8
  no_evt_in_wd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_WDOG |=> !evt_lo && !evt_hi);
endmodule

// File: rtl/tmr_dual_wd.sv
module tmr_dual_wd
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 8,
  parameter int CLK_DIV     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              ext_in0,
  input  logic              ext_in1,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              tmr_out,
  output logic              evt_lo,
  output logic              evt_hi,
  output logic              wd_expire
);
  localparam int N_EXT = 2;

  logic [N_EXT-1:0] ext_raw, ext_rise;
  logic [CNT_W-1:0] cnt_lo, cnt_hi, prd_lo, prd_hi;
  ctrl_t            ctrl;
  mode_e            mode;
  logic             ld_lo, ld_hi, svc, wd_active;

  assign ext_raw = {ext_in1, ext_in0};

  for (genvar g = 0; g < N_EXT; g++) begin : g_sync
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_raw[g]),
      .rise     (ext_rise[g])
    );
  end

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .expired   (wd_expire),
    .prd_lo    (prd_lo),
    .prd_hi    (prd_hi),
    .ctrl      (ctrl),
    .mode      (mode),
    .ld_lo     (ld_lo),
    .ld_hi     (ld_hi),
    .svc       (svc),
    .wd_active (wd_active)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .ctrl      (ctrl),
    .prd_lo    (prd_lo),
    .prd_hi    (prd_hi),
    .tick_en   (tick_en),
    .ext_rise  (ext_rise),
    .ld_lo     (ld_lo),
    .ld_hi     (ld_hi),
    .ld_val    (bus_wdata),
    .svc       (svc),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .evt_lo    (evt_lo),
    .evt_hi    (evt_hi),
    .wd_expire (wd_expire)
  );

  assign tmr_out = ctrl.out_hi ? evt_hi : evt_lo;

  // R6
  out_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_out |-> (evt_lo || evt_hi));

  // R9
  wd_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |-> wd_active);
endmodule

// File: tb/sim_tmr_dual_wd.sv
module sim_tmr_dual_wd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, ext_in0 = 1'b0, ext_in1 = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        tmr_out, evt_lo, evt_hi, wd_expire;

  int nchk = 0, nfail = 0;
  int n_elo = 0, n_ehi = 0, n_out = 0;

  always #4 clk = ~clk;

  tmr_dual_wd u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_in0(ext_in0), .ext_in1(ext_in1),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_out(tmr_out), .evt_lo(evt_lo), .evt_hi(evt_hi), .wd_expire(wd_expire)
  );

  always @(negedge clk) begin
    if (evt_lo)  n_elo++;
    if (evt_hi)  n_ehi++;
    if (tmr_out) n_out++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 0; bus_wr = 0; ext_in0 = 0; ext_in1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick(input int n, input int gap);
    repeat (n) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic clr_ev();
    @(negedge clk);
    n_elo = 0; n_ehi = 0; n_out = 0;
  endtask

  function automatic int exp_cnt(input int ticks, input int prd, input bit en);
    return en ? ticks % (prd + 1) : 0;
  endfunction

  function automatic int exp_evt(input int ticks, input int prd, input bit en);
    return en ? ticks / (prd + 1) : 0;
  endfunction

  task automatic pulse_ext(input int which, input int n);
    repeat (n) begin
      @(negedge clk);
      if (which == 0) ext_in0 = 1; else ext_in1 = 1;
      repeat (3) @(negedge clk);
      if (which == 0) ext_in0 = 0; else ext_in1 = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 8);
    nfail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    do_reset();

    // R1 reset state
    rd(8'h10, v); chk("R1 cnt_lo", v, 0);
    rd(8'h14, v); chk("R1 cnt_hi", v, 0);
    rd(8'h24, v); chk("R1 mode", v, 0);
    rd(8'h20, v); chk("R1 ctrl", v, 0);
    chk("R1 outputs", {28'h0, tmr_out, evt_lo, evt_hi, wd_expire}, 0);

    // R2 map and reserved offsets
    rd(8'h04, v); chk("R2 clkspd", v, 6);
    wr(8'h18, 32'h1234_5678); rd(8'h18, v); chk("R2 prd_lo", v, 32'h1234_5678);
    wr(8'h1C, 32'h0000_00AB); rd(8'h1C, v); chk("R2 prd_hi", v, 32'hAB);
    wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, v); chk("R2 reserved 2C", v, 0);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R2 reserved 00", v, 0);
    rd(8'h20, v); chk("R2 ctrl untouched", v, 0);
    rd(8'h18, v); chk("R2 prd_lo untouched", v, 32'h1234_5678);

    // R3 chained wrap and 64-bit match
    wr(8'h18, 1); wr(8'h1C, 1);
    wr(8'h10, 32'hFFFF_FFFE); wr(8'h14, 0);
    wr(8'h20, 32'h1);
    clr_ev();
    tick(2, 0);
    rd(8'h10, v); chk("R3 lo wrapped", v, 0);
    rd(8'h14, v); chk("R3 hi carried", v, 1);
    tick(1, 1);
    chk("R3 no early evt", n_elo, 0);
    tick(1, 1);
    rd(8'h10, v); chk("R3 lo cleared", v, 0);
    rd(8'h14, v); chk("R3 hi cleared", v, 0);
    chk("R3 one evt", n_elo, 1);

    // R11 disabled high half holds; R4 dual
    do_reset();
    wr(8'h24, 1); wr(8'h18, 100); wr(8'h1C, 100);
    wr(8'h20, 32'h1);
    tick(4, 0);
    rd(8'h10, v); chk("R11 lo counts", v, 4);
    rd(8'h14, v); chk("R11 hi held", v, 0);

    // R6 output select
    do_reset();
    wr(8'h24, 1); wr(8'h18, 0); wr(8'h1C, 0);
    wr(8'h20, 32'h11);
    clr_ev(); tick(3, 1);
    chk("R6 out_hi ignores lo", n_out, 0);
    chk("R4 lo events at prd 0", n_elo, 3);
    wr(8'h20, 32'h05);
    clr_ev(); tick(3, 1);
    chk("R6 out follows lo", n_out, 3);
    chk("R4 hi events at prd 0", n_ehi, 3);

    // R5 external sources
    do_reset();
    wr(8'h24, 1); wr(8'h18, 1000); wr(8'h1C, 1000);
    wr(8'h20, 32'h0F);
    @(negedge clk) tick_en = 1'b1;
    pulse_ext(0, 5);
    pulse_ext(1, 3);
    @(negedge clk) tick_en = 1'b0;
    repeat (6) @(negedge clk);
    rd(8'h10, v); chk("R5 lo ext edges", v, 5);
    rd(8'h14, v); chk("R5 hi ext edges", v, 3);

    // R10 write overrides tick, no event
    do_reset();
    wr(8'h24, 1); wr(8'h18, 3); wr(8'h20, 32'h1);
    tick(3, 0);
    clr_ev();
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h10; bus_wdata = 7; tick_en = 1;
    @(negedge clk);
    bus_wr = 0; tick_en = 0;
    repeat (2) @(negedge clk);
    rd(8'h10, v); chk("R10 load wins", v, 7);
    chk("R10 no evt", n_elo, 0);

    // R4 random dual-mode runs
    for (int it = 0; it < 20; it++) begin
      int plo, phi, nt, gap; bit elo, ehi;
      plo = $urandom_range(0, 15); phi = $urandom_range(0, 15);
      elo = 1'($urandom_range(0, 1)); ehi = 1'($urandom_range(0, 1));
      nt  = $urandom_range(0, 60);
      do_reset();
      wr(8'h24, 1); wr(8'h18, plo); wr(8'h1C, phi);
      wr(8'h20, {29'h0, ehi, 1'b0, elo});
      clr_ev();
      for (int k = 0; k < nt; k++) begin
        gap = $urandom_range(0, 2);
        tick(1, gap);
      end
      repeat (2) @(negedge clk);
      rd(8'h10, v); chk("R4 rand lo cnt", v, exp_cnt(nt, plo, elo));
      rd(8'h14, v); chk("R4 rand hi cnt", v, exp_cnt(nt, phi, ehi));
      chk("R4 rand lo evt", n_elo, exp_evt(nt, plo, elo));
      chk("R4 rand hi evt", n_ehi, exp_evt(nt, phi, ehi));
    end

    // R7 R8 R9 watchdog
    do_reset();
    wr(8'h18, 20); wr(8'h1C, 0);
    wr(8'h24, 2);
    rd(8'h28, v); chk("R9 wd active bit", v, 1);
    tick(10, 0);
    rd(8'h10, v); chk("R7 wd runs", v, 10);
    wr(8'h28, 32'hA5C6);
    rd(8'h28, v); chk("R9 armed bit", v, 3);
    wr(8'h28, 32'hDA7E);
    rd(8'h10, v); chk("R7 serviced", v, 0);
    tick(5, 0);
    wr(8'h28, 32'hDA7E);
    wr(8'h28, 32'hA5C6); wr(8'h28, 32'h1234); wr(8'h28, 32'hDA7E);
    rd(8'h10, v); chk("R7 bad order ignored", v, 5);
    wr(8'h24, 1);
    rd(8'h24, v); chk("R8 mode locked", v, 2);
    wr(8'h10, 3);
    rd(8'h10, v); chk("R8 cnt write ignored", v, 5);
    wr(8'h18, 2);
    rd(8'h18, v); chk("R8 prd write ignored", v, 20);
    tick(15, 0);
    chk("R9 not yet expired", wd_expire, 0);
    tick(1, 0);
    chk("R9 expired", wd_expire, 1);
    rd(8'h10, v); chk("R9 count cleared", v, 0);
    wr(8'h28, 32'hA5C6); wr(8'h28, 32'hDA7E);
    tick(5, 0);
    chk("R9 expire held", wd_expire, 1);
    do_reset();
    chk("R9 reset clears", wd_expire, 0);
    rd(8'h24, v); chk("R8 reset unlocks", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule